// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller with Shortcut Lines

The controller gathers 72 level-sensitive interrupt sources into one IRQ line and one fast-interrupt (FIQ) line. The sources form three banks: a basic bank of 8 lines and two peripheral banks of 32 lines each. Each bank has a mask. Software sets mask bits by writing ones to an enable address and clears them by writing ones to a disable address. A bank's pending word is its raw inputs ANDed with its mask.

The basic bank's pending word is the one software reads first. Above its 8 basic bits it carries two summary bits, one for each peripheral bank. Above those it carries eleven shortcut bits, which copy selected peripheral pending lines so that software can find them without a second read. A pending shortcut line does not raise its bank's summary bit. Software cannot mask the summary and shortcut bits from the basic bank. A separate control register picks one source by a flat index and routes its raw level to the FIQ output.

The register port is a single-cycle synchronous slave. A write takes effect at the clock edge on which `bus_wr` is high. Read data is combinational from `bus_addr`. Every access completes at once, so the port has no back-pressure and no handshake.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset all three masks and the FIQ control register are zero, so `irq` and `fiq` are low. Any read of a mask address returns zero.
- R2: A write to an enable address (0x18 basic, 0x10 bank 1, 0x14 bank 2) sets every mask bit where the data has a 1. A write to a disable address (0x24 basic, 0x1c bank 1, 0x20 bank 2) clears every mask bit where the data has a 1. Zero bits leave the mask as it is. A read of an enable address returns the mask. A read of a disable address returns zero.
- R3: Reads at 0x04 and 0x08 return the raw inputs of bank 1 and bank 2 ANDed with that bank's mask.
- R4: Bits 7:0 of the word at 0x00 are the basic raw inputs ANDed with the basic mask. `irq` is high exactly when any of bits 20:0 of that word is high.
- R5: Shortcut bits 10..14 of the word at 0x00 copy bank-1 pending lines 7, 9, 10, 18 and 19, in that order. Bits 15..20 copy bank-2 pending lines 21, 22, 23, 24, 25 and 30, in that order. Bits 31:21 read as zero.
- R6: Bit 8 of the word at 0x00 is high exactly when some bank-1 pending line outside its shortcut set is high. Bit 9 behaves the same way for bank 2.
- R7: Bits 8 and above in writes to the basic enable and disable addresses have no effect. A shortcut line is masked only by its own bank's mask.
- R8: The FIQ control register at 0x0c stores bits 7:0 of a write. Bits 31:8 read as zero.
- R9: `fiq` is high when control bit 7 is set and the raw level of the source picked by bits 6:0 is high. Indices 0..31 pick bank 1, 32..63 pick bank 2 and 64..71 pick the basic bank. Indices 72..127 pick nothing. The masks do not affect `fiq`.
- R10: Writes to pending or unused addresses change no state. Reads of unused addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_basic | input | 8 | Basic-bank raw levels |
| src_bank1 | input | 32 | Bank-1 raw levels |
| src_bank2 | input | 32 | Bank-2 raw levels |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The bench checks the shortcut bits one by one against every listed line, and checks each summary bit with and without a non-shortcut line beside the shortcut lines. A swapped shortcut table would put pending bits in the wrong positions. A summary that ignored the exclusion would set bit 8 or 9 for a shortcut-only event. The bench checks that basic-bank writes cannot mask shortcut lines, which a decoder that aliased the banks would let happen. It also checks the FIQ index at each bank edge, at the first unmapped index and with all masks cleared. A mux indexed off by one bank, or one gated by the masks, would show up there.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int BASIC_N = 8;
  localparam int BANK_W  = 32;
  localparam int SC1_N   = 5;
  localparam int SC2_N   = 6;
  localparam int SEL_W   = 7;

  // Register byte offsets (software relies on them).
  localparam int OFF_PEND0 = 'h00;
  localparam int OFF_PEND1 = 'h04;
  localparam int OFF_PEND2 = 'h08;
  localparam int OFF_FIQ   = 'h0c;
  localparam int OFF_EN1   = 'h10;
  localparam int OFF_EN2   = 'h14;
  localparam int OFF_EN0   = 'h18;
  localparam int OFF_DIS1  = 'h1c;
  localparam int OFF_DIS2  = 'h20;
  localparam int OFF_DIS0  = 'h24;

  // Peripheral line carried by shortcut slot k of the given bank.
  function automatic int sc_line(input int bank, input int k);
    int r;
    r = 0;
    if (bank == 1) begin
      case (k)
        0: r = 7;
        1: r = 9;
        2: r = 10;
        3: r = 18;
        default: r = 19;
      endcase
    end else begin
      case (k)
        0: r = 21;
        1: r = 22;
        2: r = 23;
        3: r = 24;
        4: r = 25;
        default: r = 30;
      endcase
    end
    return r;
  endfunction

  function automatic logic [BANK_W-1:0] sc_mask(input int bank, input int n);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int k = 0; k < n; k++) m[sc_line(bank, k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ictl_mask_reg.sv
module ictl_mask_reg #(
  parameter int W    = 32,
  parameter int LIVE = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  localparam logic [W-1:0] LIVE_MASK = (LIVE >= W) ? '1 : W'((64'd1 << LIVE) - 64'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (set_we) begin
      mask_q <= (mask_q | wdata) & LIVE_MASK;
    end else if (clr_we) begin
      mask_q <= mask_q & ~wdata & LIVE_MASK;
    end
  end
endmodule

// File: rtl/ictl_bank_front.sv
module ictl_bank_front #(
  parameter int W       = 32,
  parameter int BANK_ID = 1,
  parameter int N_SC    = 5
) (
  input  logic [W-1:0]    raw,
  input  logic [W-1:0]    mask,
  output logic [W-1:0]    pend,
  output logic [N_SC-1:0] sc_bits,
  output logic            summary
);
  localparam logic [W-1:0] SC_SET = W'(ictl_pkg::sc_mask(BANK_ID, N_SC));

  assign pend    = raw & mask;
  assign summary = |(pend & ~SC_SET);

  for (genvar k = 0; k < N_SC; k++) begin : g_sc
    localparam int LINE = ictl_pkg::sc_line(BANK_ID, k);
    assign sc_bits[k] = pend[LINE];
  end
endmodule

// File: rtl/ictl_fiq_route.sv
module ictl_fiq_route #(
  parameter int W     = 32,
  parameter int SEL_W = 7,
  parameter int N_SRC = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [W-1:0]     wdata,
  input  logic [N_SRC-1:0] raw_all,
  output logic [W-1:0]     ctrl_q,
  output logic             fiq
);
  localparam int SPAN = 1 << SEL_W;
  localparam logic [W-1:0] KEEP = W'((64'd1 << (SEL_W + 1)) - 64'd1);

  logic [SPAN-1:0]  raw_pad;
  logic [SEL_W-1:0] sel;

  assign raw_pad = SPAN'(raw_all);
  assign sel     = ctrl_q[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (we) ctrl_q <= wdata & KEEP;
  end

  assign fiq = ctrl_q[SEL_W] & raw_pad[sel];
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [ictl_pkg::BASIC_N-1:0] src_basic,
  input  logic [ictl_pkg::BANK_W-1:0]  src_bank1,
  input  logic [ictl_pkg::BANK_W-1:0]  src_bank2,
  output logic                        irq,
  output logic                        fiq
);
  import ictl_pkg::*;

  localparam int N_SRC  = 2 * BANK_W + BASIC_N;
  localparam int P0_W   = BASIC_N + 2 + SC1_N + SC2_N;
  localparam logic [ADDR_W-1:0] A_PEND0 = ADDR_W'(OFF_PEND0);
  localparam logic [ADDR_W-1:0] A_PEND1 = ADDR_W'(OFF_PEND1);
  localparam logic [ADDR_W-1:0] A_PEND2 = ADDR_W'(OFF_PEND2);
  localparam logic [ADDR_W-1:0] A_FIQ   = ADDR_W'(OFF_FIQ);
  localparam logic [ADDR_W-1:0] A_EN0   = ADDR_W'(OFF_EN0);
  localparam logic [ADDR_W-1:0] A_EN1   = ADDR_W'(OFF_EN1);
  localparam logic [ADDR_W-1:0] A_EN2   = ADDR_W'(OFF_EN2);
  localparam logic [ADDR_W-1:0] A_DIS0  = ADDR_W'(OFF_DIS0);
  localparam logic [ADDR_W-1:0] A_DIS1  = ADDR_W'(OFF_DIS1);
  localparam logic [ADDR_W-1:0] A_DIS2  = ADDR_W'(OFF_DIS2);

  logic [DATA_W-1:0] en0_q, en1_q, en2_q, fiq_ctl_q;
  logic [BANK_W-1:0] pend1, pend2;
  logic [SC1_N-1:0]  sc1;
  logic [SC2_N-1:0]  sc2;
  logic              sum1, sum2;
  logic [P0_W-1:0]   pend0;

  ictl_mask_reg #(.W(DATA_W), .LIVE(BASIC_N)) u_en0 (
    .clk(clk), .rst_n(rst_n),
    .set_we(bus_wr && bus_addr == A_EN0), .clr_we(bus_wr && bus_addr == A_DIS0),
    .wdata(bus_wdata), .mask_q(en0_q)
  );
  ictl_mask_reg #(.W(DATA_W), .LIVE(BANK_W)) u_en1 (
    .clk(clk), .rst_n(rst_n),
    .set_we(bus_wr && bus_addr == A_EN1), .clr_we(bus_wr && bus_addr == A_DIS1),
    .wdata(bus_wdata), .mask_q(en1_q)
  );
  ictl_mask_reg #(.W(DATA_W), .LIVE(BANK_W)) u_en2 (
    .clk(clk), .rst_n(rst_n),
    .set_we(bus_wr && bus_addr == A_EN2), .clr_we(bus_wr && bus_addr == A_DIS2),
    .wdata(bus_wdata), .mask_q(en2_q)
  );

  ictl_bank_front #(.W(BANK_W), .BANK_ID(1), .N_SC(SC1_N)) u_bank1 (
    .raw(src_bank1), .mask(en1_q[BANK_W-1:0]),
    .pend(pend1), .sc_bits(sc1), .summary(sum1)
  );
  ictl_bank_front #(.W(BANK_W), .BANK_ID(2), .N_SC(SC2_N)) u_bank2 (
    .raw(src_bank2), .mask(en2_q[BANK_W-1:0]),
    .pend(pend2), .sc_bits(sc2), .summary(sum2)
  );

  ictl_fiq_route #(.W(DATA_W), .SEL_W(SEL_W), .N_SRC(N_SRC)) u_fiq (
    .clk(clk), .rst_n(rst_n),
    .we(bus_wr && bus_addr == A_FIQ), .wdata(bus_wdata),
    .raw_all({src_basic, src_bank2, src_bank1}),
    .ctrl_q(fiq_ctl_q), .fiq(fiq)
  );

  assign pend0 = {sc2, sc1, sum2, sum1, src_basic & en0_q[BASIC_N-1:0]};
  assign irq   = |pend0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PEND0: bus_rdata = DATA_W'(pend0);
      A_PEND1: bus_rdata = DATA_W'(pend1);
      A_PEND2: bus_rdata = DATA_W'(pend2);
      A_FIQ:   bus_rdata = fiq_ctl_q;
      A_EN0:   bus_rdata = en0_q;
      A_EN1:   bus_rdata = en1_q;
      A_EN2:   bus_rdata = en2_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ictl_checker.sv
module ictl_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              fiq,
  input logic [DATA_W-1:0] en0,
  input logic [DATA_W-1:0] en1,
  input logic [DATA_W-1:0] en2,
  input logic [DATA_W-1:0] fiq_ctl,
  input logic [31:0]       pend1,
  input logic [31:0]       pend2,
  input logic              sum1,
  input logic              sum2
);
  localparam logic [ADDR_W-1:0] A_EN1  = ADDR_W'(ictl_pkg::OFF_EN1);
  localparam logic [ADDR_W-1:0] A_DIS1 = ADDR_W'(ictl_pkg::OFF_DIS1);
  localparam logic [ADDR_W-1:0] A_EN0  = ADDR_W'(ictl_pkg::OFF_EN0);
  localparam logic [ADDR_W-1:0] A_DIS0 = ADDR_W'(ictl_pkg::OFF_DIS0);
  localparam logic [ADDR_W-1:0] A_FIQ  = ADDR_W'(ictl_pkg::OFF_FIQ);

  p_no_mask_no_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 == '0 && en1 == '0 && en2 == '0) |-> !irq);

  p_enable_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EN1) |=> ((en1 & $past(bus_wdata)) == $past(bus_wdata)));

  p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIS1) |=> ((en1 & $past(bus_wdata)) == '0));

  p_summary1_real_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sum1 |-> (pend1 != '0));

  p_summary2_real_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sum2 |-> (pend2 != '0));

  p_basic_write_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_EN0 || bus_addr == A_DIS0)) |=>
      (en1 == $past(en1) && en2 == $past(en2)));

  p_fiq_ctl_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_FIQ) |-> (bus_rdata[DATA_W-1:8] == '0));

  p_fiq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> fiq_ctl[7]);
endmodule

bind banked_irq_ctrl ictl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .fiq(fiq),
  .en0(en0_q), .en1(en1_q), .en2(en2_q), .fiq_ctl(fiq_ctl_q),
  .pend1(pend1), .pend2(pend2), .sum1(sum1), .sum2(sum2)
);

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  src_basic = '0;
  logic [31:0] src_bank1 = '0;
  logic [31:0] src_bank2 = '0;
  logic        irq, fiq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  banked_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_basic(src_basic),
    .src_bank1(src_bank1), .src_bank2(src_bank2), .irq(irq), .fiq(fiq)
  );

  // Row layout: basic(8) bank1(32) bank2(32) expected word at 0x00 (32); all masks open.
  localparam int ROWS = 10;
  localparam logic [103:0] VEC [ROWS] = '{
    {8'h00, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {8'h05, 32'h0000_0000, 32'h0000_0000, 32'h0000_0005},
    {8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0100},
    {8'h00, 32'h0000_0080, 32'h0000_0000, 32'h0000_0400},
    {8'h00, 32'h0000_0000, 32'h4000_0000, 32'h0010_0000},
    {8'h00, 32'h0000_0000, 32'h0020_0001, 32'h0000_8200},
    {8'h00, 32'h0008_0200, 32'h0000_0000, 32'h0000_4800},
    {8'h00, 32'h0000_0400, 32'h0200_0000, 32'h0008_1000},
    {8'h00, 32'h0004_0000, 32'h01C0_0000, 32'h0007_2000},
    {8'h80, 32'h8000_0000, 32'h0000_0000, 32'h0000_0180}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FIAL_MARK");
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #2;
    check(tag, bus_rdata, exp);
  endtask

  task automatic set_src(input logic [7:0] s0, input logic [31:0] s1, input logic [31:0] s2);
    @(negedge clk);
    src_basic = s0; src_bank1 = s1; src_bank2 = s2;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 fiq", {31'b0, fiq}, 32'h0);
    rd_check("R1 en1", 6'h10, 32'h0);
    rd_check("R1 en2", 6'h14, 32'h0);
    rd_check("R1 en0", 6'h18, 32'h0);
    rd_check("R1 fiqctl", 6'h0c, 32'h0);

    // R2 set/clear semantics
    wr(6'h10, 32'h0000_000F);
    wr(6'h10, 32'h0000_00F0);
    rd_check("R2 en1 set", 6'h10, 32'h0000_00FF);
    wr(6'h1c, 32'h0000_000C);
    rd_check("R2 en1 clear", 6'h10, 32'h0000_00F3);
    rd_check("R2 disable reads 0", 6'h1c, 32'h0);

    // R3 bank pending
    set_src(8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd_check("R3 pend1", 6'h04, 32'h0000_00F3);
    rd_check("R3 pend2 masked", 6'h08, 32'h0);

    // R7 shortcut mask lives in its own bank
    wr(6'h1c, 32'hFFFF_FFFF);
    set_src(8'h00, 32'h0000_0080, 32'h0);
    wr(6'h18, 32'hFFFF_FFFF);
    rd_check("R7 basic enable no shortcut effect", 6'h00, 32'h0);
    check("R7 irq low", {31'b0, irq}, 32'h0);
    wr(6'h10, 32'h0000_0080);
    rd_check("R5 shortcut via bank mask", 6'h00, 32'h0000_0400);
    rd_check("R3 pend1 line7", 6'h04, 32'h0000_0080);
    wr(6'h24, 32'hFFFF_FF00);
    rd_check("R7 basic disable upper no effect", 6'h00, 32'h0000_0400);
    rd_check("R2 en0 readback", 6'h18, 32'h0000_00FF);

    // Table walk: R4 R5 R6 with all masks open
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF);
    for (int i = 0; i < ROWS; i++) begin
      set_src(VEC[i][103:96], VEC[i][95:64], VEC[i][63:32]);
      rd_check("R4 R5 R6 pend0 row", 6'h00, VEC[i][31:0]);
      check("R4 irq row", {31'b0, irq}, {31'b0, (VEC[i][31:0] != 32'h0)});
    end

    // R8 / R9 FIQ routing, masks all closed
    wr(6'h1c, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    wr(6'h24, 32'hFFFF_FFFF);
    set_src(8'h00, 32'h0, 32'h0);
    wr(6'h0c, 32'hFFFF_FF85);
    rd_check("R8 fiq ctl readback", 6'h0c, 32'h0000_0085);
    set_src(8'h00, 32'h0000_0020, 32'h0);
    check("R9 fiq bank1 line5", {31'b0, fiq}, 32'h1);
    check("R9 irq independent", {31'b0, irq}, 32'h0);
    set_src(8'h00, 32'h0, 32'h0);
    check("R9 fiq follows level", {31'b0, fiq}, 32'h0);
    wr(6'h0c, 32'h0000_00C3);
    set_src(8'h08, 32'h0, 32'h0);
    check("R9 fiq basic line3", {31'b0, fiq}, 32'h1);
    wr(6'h0c, 32'h0000_00A8);
    set_src(8'h00, 32'h0, 32'h0000_0100);
    check("R9 fiq bank2 line8", {31'b0, fiq}, 32'h1);
    set_src(8'h00, 32'h0, 32'h0000_0080);
    check("R9 fiq bank2 other line", {31'b0, fiq}, 32'h0);
    wr(6'h0c, 32'h0000_00C8);
    set_src(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R9 fiq index 72 none", {31'b0, fiq}, 32'h0);
    wr(6'h0c, 32'h0000_0005);
    set_src(8'h00, 32'h0000_0020, 32'h0);
    check("R9 fiq disabled", {31'b0, fiq}, 32'h0);

    // R10 pending and unused addresses
    set_src(8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h28, 32'hFFFF_FFFF);
    rd_check("R10 pend1 write ignored", 6'h04, 32'h0);
    rd_check("R10 unused reads 0", 6'h28, 32'h0);
    check("R10 irq stays low", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule